// File: doc/BRIEF.md
# Serial Flash Register Write-Guard Front End

This block is the serial-interface front end that owns the status and configuration registers of a serial flash device. It receives SPI mode-0 frames from a host: chip select, serial clock and data in. It oversamples them with its own system clock and decodes the first byte of each frame as an instruction. It executes a small register command set. That set covers setting and clearing a write latch, writing the status and configuration registers, reading the status register back, and arming a one-shot redirect. The redirect sends the next register write into a bank address register.

The central job of the block is deciding whether a register write is allowed. A write needs the write latch to have been set by an earlier frame. A sticky lock bit in the status register, together with an active-low guard pin, can refuse the write in hardware. The guard pin loses this power when the quad-mode bit of the configuration register is set, because in that mode the pin is used as a data line. Every completed register write, whether granted or refused, drops the write latch. It also reports its outcome on a one-cycle done strobe with an accept flag.

Top module: `flash_reg_guard`

## Requirements
- R1: After reset the status, configuration and bank outputs read 00h, the done strobe is low and the serial output driver is disabled.
- R2: A frame of exactly 8 bits with instruction 06h sets the write latch (status bit 1). A frame of exactly 8 bits with instruction 04h clears it.
- R3: A register-write frame (instruction 01h) that arrives while the write latch is clear is refused: wr_acc is 0 and both registers keep their values.
- R4: While the lock bit (status bit 7) is 0 and the latch is set, a register write is granted at either guard-pin level. Status bits 7..2 take bits 7..2 of the first data byte. Status bit 1 always shows the latch and bit 0 always reads 0.
- R5: While the lock bit is 1, the guard pin is low and quad mode (configuration bit 1) is 0, a register write is refused even with the latch set, and both registers keep their values.
- R6: While the lock bit is 1 and the guard pin is high, a register write with the latch set is granted.
- R7: While quad mode is 1, the guard pin has no effect and a register write with the latch set is granted even with the lock bit at 1.
- R8: A granted write of 24 bits (instruction plus two data bytes, MSB first) loads the second data byte into the configuration register. A granted write of 16 bits updates only the status register.
- R9: A frame that ends off a byte boundary, or a register-write frame with fewer than 8 data bits, commits nothing. The latch keeps its value and no done strobe appears.
- R10: Every committed register write, granted or refused, clears the write latch and raises wr_done for exactly one clock. wr_acc holds the outcome until the next one.
- R11: A register-write frame that comes right after an 8-bit frame with instruction B9h loads its first data byte into the bank register. The status register, configuration register and latch stay as they were, and there is no done strobe. Any other frame in between cancels the redirect.
- R12: After instruction 05h the status register is shifted out MSB first, changing on falling serial-clock edges and repeating every 8 bits. The output driver is enabled only in that data phase and stays off for the whole of a register-write frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Frame select, active low |
| spi_clk | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data from host |
| hw_guard_n | input | 1 | Hardware write-guard pin, active low |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output driver enable for spi_miso (low means high impedance) |
| status_out | output | 8 | Status register view: lock, free bits, protect bits, latch, busy |
| config_out | output | 8 | Configuration register, bit 1 is quad mode |
| bank_out | output | 8 | Bank address register |
| wr_done | output | 1 | One-clock strobe when a register write is decided |
| wr_acc | output | 1 | Outcome of the most recent register write (1 granted) |

## Verification
Each pin passes two synchroniser stages, and one further register turns a detected edge into a state change. Register, latch, done and accept results therefore appear on the third rising clock edge after the pin change. A shifted-out status bit is likewise valid three edges after the serial-clock fall that moves it. The behavioural model in the bench records the edge count at which chip select was raised and applies its predicted values exactly three edges later. Comparing on every falling clock edge pins the done strobe to its single cycle. The bench holds each serial-clock phase for six system clocks and samples spi_miso and the driver enable just before each rising serial edge, well after they are due.

// File: rtl/flash_guard_pkg.sv
// Shared constants for the flash register write-guard front end.
// Assumes 8-bit serial bytes and at most three bytes of interest per frame.
package flash_guard_pkg;
    localparam int BYTE_W = 8;
    localparam int POS_W  = $clog2(BYTE_W);
    localparam int CNT_W  = 2;

    typedef logic [BYTE_W-1:0] byte_t;

    // Instruction codes
    localparam byte_t OP_REG_WRITE = 8'h01;
    localparam byte_t OP_LATCH_CLR = 8'h04;
    localparam byte_t OP_STAT_READ = 8'h05;
    localparam byte_t OP_LATCH_SET = 8'h06;
    localparam byte_t OP_BANK_ARM  = 8'hB9;

    // Bit positions that the grant logic decodes
    localparam int ST_LOCK  = 7;
    localparam int CFG_QUAD = 1;
endpackage

// File: rtl/spi_pin_sync.sv
// Synchroniser chain for a group of asynchronous pins with edge detection.
// Assumes pins are slow compared with clk (several clocks per level).
module spi_pin_sync #(
    parameter int            STAGES  = 2,
    parameter int            W       = 4,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    output logic [W-1:0] q,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] stg [STAGES];
    logic [W-1:0] prev;

    // Shift the pin group through the synchroniser chain and keep last value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
            prev <= RST_VAL;
        end else begin
            stg[0] <= pins;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            prev <= stg[STAGES-1];
        end
    end

    assign q    = stg[STAGES-1];
    assign rise = q & ~prev;
    assign fall = ~q & prev;
endmodule

// File: rtl/spi_byte_rx.sv
// Assembles serial bits into bytes, MSB first, and counts bytes per frame.
// Assumes start and sample never coincide (chip select settles before clocking).
module spi_byte_rx
    import flash_guard_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             active,
    input  logic             sample,
    input  logic             din,
    output logic             byte_stb,
    output byte_t            byte_val,
    output logic [CNT_W-1:0] byte_idx,
    output logic [POS_W-1:0] bit_pos,
    output logic [CNT_W-1:0] byte_cnt
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] CNT_SAT  = '1;

    byte_t shreg;

    // Shift in one bit per sampling edge and emit a strobe per whole byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_pos  <= '0;
            byte_cnt <= '0;
            byte_stb <= 1'b0;
            byte_val <= '0;
            byte_idx <= '0;
        end else begin
            byte_stb <= 1'b0;
            if (start) begin
                bit_pos  <= '0;
                byte_cnt <= '0;
            end else if (active && sample) begin
                shreg   <= {shreg[BYTE_W-2:0], din};
                bit_pos <= bit_pos + 1'b1;
                if (bit_pos == LAST_POS) begin
                    byte_stb <= 1'b1;
                    byte_val <= {shreg[BYTE_W-2:0], din};
                    byte_idx <= byte_cnt;
                    if (byte_cnt != CNT_SAT) byte_cnt <= byte_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_status_tx.sv
// Shifts a byte out MSB first on falling serial-clock edges, reloading each byte.
// Assumes bit_pos is zero at the falling edge that follows each completed byte.
module spi_status_tx
    import flash_guard_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             shift_evt,
    input  logic [POS_W-1:0] bit_pos,
    input  byte_t            load_val,
    output logic             dout
);
    byte_t shreg;

    // Reload on a byte boundary, otherwise move the next bit to the top
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (en && shift_evt) begin
            if (bit_pos == '0) shreg <= load_val;
            else               shreg <= {shreg[BYTE_W-2:0], 1'b0};
        end
    end

    assign dout = shreg[BYTE_W-1];
endmodule

// File: rtl/flash_reg_guard.sv
// Command front end for the status, configuration and bank registers of a
// serial flash. Decodes one-byte instructions, keeps the write latch and
// decides whether a register write is granted from the latch, the lock bit,
// the guard pin and quad mode. Assumes SPI mode 0 and a clk at least
// eight times faster than the serial clock.
module flash_reg_guard
    import flash_guard_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spi_cs_n,
    input  logic        spi_clk,
    input  logic        spi_mosi,
    input  logic        hw_guard_n,
    output logic        spi_miso,
    output logic        spi_miso_oe,
    output logic [7:0]  status_out,
    output logic [7:0]  config_out,
    output logic [7:0]  bank_out,
    output logic        wr_done,
    output logic        wr_acc
);
    localparam int PIN_W    = 4;
    localparam int PI_CS    = 3;
    localparam int PI_SCK   = 2;
    localparam int PI_MOSI  = 1;
    localparam int PI_GUARD = 0;
    localparam logic [PIN_W-1:0] PIN_RST = 4'b1001;

    logic [PIN_W-1:0] pin_q, pin_rise, pin_fall;
    logic             cs_q, guard_q, cs_rise, cs_fall, sck_rise, sck_fall;
    logic             unused_edges;

    logic             byte_stb;
    byte_t            byte_val;
    logic [CNT_W-1:0] byte_idx, byte_cnt;
    logic [POS_W-1:0] bit_pos;

    byte_t            opcode_q, data1_q, data2_q, cfg_q, bank_q;
    logic [7:2]       stat_hi;
    logic             latch_q, armed_q, rd_mode_q, wr_done_q, wr_acc_q;
    byte_t            status_view;
    logic             frame_whole, one_byte, reg_frame, hw_block, grant;

    spi_pin_sync #(
        .STAGES  (SYNC_STAGES),
        .W       (PIN_W),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  ({spi_cs_n, spi_clk, spi_mosi, hw_guard_n}),
        .q     (pin_q),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    assign cs_q         = pin_q[PI_CS];
    assign guard_q      = pin_q[PI_GUARD];
    assign cs_rise      = pin_rise[PI_CS];
    assign cs_fall      = pin_fall[PI_CS];
    assign sck_rise     = pin_rise[PI_SCK];
    assign sck_fall     = pin_fall[PI_SCK];
    assign unused_edges = ^{pin_rise[PI_MOSI], pin_rise[PI_GUARD],
                            pin_fall[PI_MOSI], pin_fall[PI_GUARD]};

    spi_byte_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cs_fall),
        .active   (!cs_q),
        .sample   (sck_rise),
        .din      (pin_q[PI_MOSI]),
        .byte_stb (byte_stb),
        .byte_val (byte_val),
        .byte_idx (byte_idx),
        .bit_pos  (bit_pos),
        .byte_cnt (byte_cnt)
    );

    assign status_view = {stat_hi, latch_q, 1'b0};

    spi_status_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (rd_mode_q),
        .shift_evt (sck_fall),
        .bit_pos   (bit_pos),
        .load_val  (status_view),
        .dout      (spi_miso)
    );

    // Capture the instruction and the first two data bytes of a frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode_q <= '0;
            data1_q  <= '0;
            data2_q  <= '0;
        end else if (byte_stb) begin
            case (byte_idx)
                2'd0:    opcode_q <= byte_val;
                2'd1:    data1_q  <= byte_val;
                2'd2:    data2_q  <= byte_val;
                default: ;
            endcase
        end
    end

    // Enter read-out after a status-read instruction, leave at frame edges
    always_ff @(posedge clk) begin
        if (!rst_n)                   rd_mode_q <= 1'b0;
        else if (cs_rise || cs_fall)  rd_mode_q <= 1'b0;
        else if (byte_stb && byte_idx == '0 && byte_val == OP_STAT_READ)
                                      rd_mode_q <= 1'b1;
    end

    // Frame classification and the write grant decision
    always_comb begin
        frame_whole = (bit_pos == '0);
        one_byte    = frame_whole && (byte_cnt == 2'd1);
        reg_frame   = cs_rise && frame_whole && (byte_cnt >= 2'd2)
                      && (opcode_q == OP_REG_WRITE);
        hw_block    = stat_hi[ST_LOCK] && !guard_q && !cfg_q[CFG_QUAD];
        grant       = latch_q && !hw_block;
    end

    // Commit the effect of a frame when chip select returns high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_hi   <= '0;
            cfg_q     <= '0;
            bank_q    <= '0;
            latch_q   <= 1'b0;
            armed_q   <= 1'b0;
            wr_done_q <= 1'b0;
            wr_acc_q  <= 1'b0;
        end else begin
            wr_done_q <= 1'b0;
            if (cs_rise) begin
                armed_q <= one_byte && (opcode_q == OP_BANK_ARM);
                if (one_byte && opcode_q == OP_LATCH_SET) latch_q <= 1'b1;
                if (one_byte && opcode_q == OP_LATCH_CLR) latch_q <= 1'b0;
                if (reg_frame && armed_q) begin
                    bank_q <= data1_q;
                end else if (reg_frame) begin
                    wr_done_q <= 1'b1;
                    wr_acc_q  <= grant;
                    latch_q   <= 1'b0;
                    if (grant) begin
                        stat_hi <= data1_q[7:2];
                        if (byte_cnt == 2'd3) cfg_q <= data2_q;
                    end
                end
            end
        end
    end

    assign spi_miso_oe = rd_mode_q && !cs_q;
    assign status_out  = status_view;
    assign config_out  = cfg_q;
    assign bank_out    = bank_q;
    assign wr_done     = wr_done_q;
    assign wr_acc      = wr_acc_q;
endmodule

// File: rtl/flash_reg_guard_chk.sv
// Property checker for flash_reg_guard, attached by bind below.
// Observes the register outputs, the outcome flags and the synchronised pins.
module flash_reg_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] status_out,
    input logic [7:0] config_out,
    input logic       wr_done,
    input logic       wr_acc,
    input logic       spi_miso_oe,
    input logic       cs_q,
    input logic       guard_q
);
    AST_CFG_ONLY_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(config_out) |-> (wr_done && wr_acc)); // R8

    AST_STAT_ONLY_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status_out[7:2]) |-> (wr_done && wr_acc)); // R4

    AST_GRANT_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && wr_acc) |-> $past(status_out[1])); // R3

    AST_GUARD_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && $past(status_out[7] && !guard_q && !config_out[1])) |-> !wr_acc); // R5

    AST_LATCH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> !status_out[1]); // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done); // R10

    AST_OE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        spi_miso_oe |-> !cs_q); // R12
endmodule

bind flash_reg_guard flash_reg_guard_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .status_out  (status_out),
    .config_out  (config_out),
    .wr_done     (wr_done),
    .wr_acc      (wr_acc),
    .spi_miso_oe (spi_miso_oe),
    .cs_q        (cs_q),
    .guard_q     (guard_q)
);

// File: tb/sim_flash_reg_guard.sv
// Bench for flash_reg_guard: drives SPI frames and compares every clock
// against a behavioural model that applies its predictions DUE edges later.
module sim_flash_reg_guard;
    localparam int H   = 6;   // system clocks per serial half-period
    localparam int DUE = 3;   // edges from pin change to result

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_cs_n = 1'b1, spi_clk = 1'b0, spi_mosi = 1'b0, hw_guard_n = 1'b1;
    logic spi_miso, spi_miso_oe, wr_done, wr_acc;
    logic [7:0] status_out, config_out, bank_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // model: logical state
    logic [7:0] m_stat = 8'h00, m_cfg = 8'h00, m_bank = 8'h00;
    logic       m_latch = 1'b0, m_armed = 1'b0, m_acc = 1'b0;
    // model: visible state
    logic [7:0] e_stat = 8'h00, e_cfg = 8'h00, e_bank = 8'h00;
    logic       e_acc = 1'b0, e_done = 1'b0;
    int         pend_due = -1;
    logic       pend_wr = 1'b0;

    always #2 clk = ~clk;

    flash_reg_guard u0 (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_clk(spi_clk),
        .spi_mosi(spi_mosi), .hw_guard_n(hw_guard_n), .spi_miso(spi_miso),
        .spi_miso_oe(spi_miso_oe), .status_out(status_out),
        .config_out(config_out), .bank_out(bank_out),
        .wr_done(wr_done), .wr_acc(wr_acc)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act %h exp %h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // per-clock comparison against the model's visible state
    always @(negedge clk) begin
        if (rst_n) begin
            e_done = 1'b0;
            if (pend_due >= 0 && cyc == pend_due) begin
                e_stat = {m_stat[7:2], m_latch, 1'b0};
                e_cfg  = m_cfg;
                e_bank = m_bank;
                e_acc  = m_acc;
                e_done = pend_wr;
                pend_due = -1;
            end
            chk("R4 status per clock", status_out, e_stat);
            chk("R8 config per clock", config_out, e_cfg);
            chk("R11 bank per clock", bank_out, e_bank);
            chk("R10 done per clock", {7'd0, wr_done}, {7'd0, e_done});
            chk("R10 accept per clock", {7'd0, wr_acc}, {7'd0, e_acc});
        end
    end

    // model of the frame commit at chip-select rise
    task automatic model_commit(input int nbits, input logic [7:0] b0,
                                input logic [7:0] b1, input logic [7:0] b2);
        bit whole, lock_hw, ok, next_armed;
        int nb;
        whole = (nbits % 8) == 0;
        nb = nbits / 8;
        next_armed = whole && nb == 1 && b0 == 8'hB9;
        pend_wr = 1'b0;
        if (whole && nb == 1 && b0 == 8'h06) m_latch = 1'b1;
        if (whole && nb == 1 && b0 == 8'h04) m_latch = 1'b0;
        if (whole && nb >= 2 && b0 == 8'h01) begin
            if (m_armed) m_bank = b1;
            else begin
                lock_hw = m_stat[7] && !hw_guard_n && !m_cfg[1];
                ok = m_latch && !lock_hw;
                m_acc = ok;
                m_latch = 1'b0;
                pend_wr = 1'b1;
                if (ok) begin
                    m_stat = {b1[7:2], 2'b00};
                    if (nb >= 3) m_cfg = b2;
                end
            end
        end
        m_armed = next_armed;
        pend_due = cyc + DUE;
    endtask

    task automatic xfer_byte(input logic [7:0] b, input int nbits, input int oe_exp,
                             input logic [7:0] rd_exp);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = b[7-i];
            tick(H);
            if (oe_exp >= 0) chk("R12 driver enable", {7'd0, spi_miso_oe}, oe_exp[7:0]);
            if (oe_exp == 1) chk("R12 read bit", {7'd0, spi_miso}, {7'd0, rd_exp[7-i]});
            spi_clk = 1'b1;
            tick(H);
            spi_clk = 1'b0;
        end
    endtask

    task automatic frame(input int nbits, input logic [7:0] b0,
                         input logic [7:0] b1, input logic [7:0] b2);
        int left;
        logic [7:0] bs [3];
        bs[0] = b0; bs[1] = b1; bs[2] = b2;
        left = nbits;
        spi_cs_n = 1'b0;
        tick(4);
        for (int k = 0; k < 3 && left > 0; k++) begin
            xfer_byte(bs[k], (left > 8) ? 8 : left, 0, 8'h00);
            left -= 8;
        end
        tick(2);
        spi_cs_n = 1'b1;
        model_commit(nbits, b0, b1, b2);
        tick(10);
    endtask

    task automatic read_status(input int nbytes, input logic [7:0] exp);
        spi_cs_n = 1'b0;
        tick(4);
        xfer_byte(8'h05, 8, 0, 8'h00);
        for (int k = 0; k < nbytes; k++) xfer_byte(8'h00, 8, 1, exp);
        tick(2);
        spi_cs_n = 1'b1;
        model_commit(8 + 8 * nbytes, 8'h05, 8'h00, 8'h00);
        tick(10);
        chk("R12 driver off after frame", {7'd0, spi_miso_oe}, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act running exp finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(2);
        chk("R1 reset status", status_out, 8'h00);
        chk("R1 reset config", config_out, 8'h00);
        chk("R1 reset bank", bank_out, 8'h00);
        chk("R1 reset done", {7'd0, wr_done}, 8'h00);
        chk("R1 reset driver", {7'd0, spi_miso_oe}, 8'h00);

        // write without latch
        frame(24, 8'h01, 8'hAA, 8'h55);
        chk("R3 refused status", status_out, 8'h00);
        chk("R3 refused config", config_out, 8'h00);
        chk("R3 refused flag", {7'd0, wr_acc}, 8'h00);

        // latch set and clear
        frame(8, 8'h06, 8'h00, 8'h00);
        chk("R2 latch set", status_out, 8'h02);
        frame(8, 8'h04, 8'h00, 8'h00);
        chk("R2 latch clear", status_out, 8'h00);

        // lock clear, guard low: granted, low bits not taken
        hw_guard_n = 1'b0;
        frame(8, 8'h06, 8'h00, 8'h00);
        frame(24, 8'h01, 8'h9F, 8'h00);
        chk("R4 granted with guard low", status_out, 8'h9C);
        chk("R10 granted flag", {7'd0, wr_acc}, 8'h01);

        // lock set, guard low, quad off: refused
        frame(8, 8'h06, 8'h00, 8'h00);
        chk("R2 latch before refusal", status_out, 8'h9E);
        frame(24, 8'h01, 8'h00, 8'hFF);
        chk("R5 hardware refusal status", status_out, 8'h9C);
        chk("R5 hardware refusal config", config_out, 8'h00);
        chk("R10 refusal flag", {7'd0, wr_acc}, 8'h00);

        // lock set, guard high: granted, config loaded
        hw_guard_n = 1'b1;
        frame(8, 8'h06, 8'h00, 8'h00);
        frame(24, 8'h01, 8'h84, 8'h02);
        chk("R6 guard high granted", status_out, 8'h84);
        chk("R8 config from second byte", config_out, 8'h02);

        // quad on, guard low: guard ignored
        hw_guard_n = 1'b0;
        frame(8, 8'h06, 8'h00, 8'h00);
        frame(24, 8'h01, 8'h90, 8'h06);
        chk("R7 quad overrides guard", status_out, 8'h90);
        chk("R7 quad config", config_out, 8'h06);

        // 16-bit write touches status only
        frame(8, 8'h06, 8'h00, 8'h00);
        frame(16, 8'h01, 8'h88, 8'h00);
        chk("R8 short write status", status_out, 8'h88);
        chk("R8 short write config kept", config_out, 8'h06);

        // incomplete frames commit nothing
        frame(8, 8'h06, 8'h00, 8'h00);
        frame(12, 8'h01, 8'hAA, 8'h00);
        chk("R9 partial byte ignored", status_out, 8'h8A);
        frame(8, 8'h01, 8'h00, 8'h00);
        chk("R9 no data ignored", status_out, 8'h8A);

        // bank redirect
        frame(8, 8'hB9, 8'h00, 8'h00);
        frame(16, 8'h01, 8'h5A, 8'h00);
        chk("R11 bank loaded", bank_out, 8'h5A);
        chk("R11 status kept with latch", status_out, 8'h8A);
        frame(8, 8'hB9, 8'h00, 8'h00);
        read_status(1, 8'h8A);
        frame(16, 8'h01, 8'h33, 8'h00);
        chk("R11 redirect cancelled bank", bank_out, 8'h5A);
        chk("R11 redirect cancelled status", status_out, 8'h30);

        // status read-out repeats
        frame(8, 8'h06, 8'h00, 8'h00);
        read_status(2, 8'h32);

        // quad off again, then full hardware lock
        hw_guard_n = 1'b1;
        frame(24, 8'h01, 8'h80, 8'h00);
        chk("R5 prep status", status_out, 8'h80);
        chk("R5 prep config", config_out, 8'h00);
        hw_guard_n = 1'b0;
        frame(8, 8'h06, 8'h00, 8'h00);
        frame(24, 8'h01, 8'h00, 8'hFF);
        chk("R5 locked status", status_out, 8'h80);
        chk("R5 locked config", config_out, 8'h00);

        tick(20);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule